// File: doc/BRIEF.md
# Per-Port Ethernet Statistics Counter Bank

This block keeps the frame statistics of a multi-port Ethernet switch. Each port's receive MAC and transmit MAC hand it one strobe per finished frame. The strobe carries the frame length, a frame-class code and an error or fault code. The block decides which counters that frame touches and bumps them in the same clock. These are the cast counters, a length bin, an error or fault counter, collision and deferral counters, and byte totals.

Software reads the counters one 32-bit word at a time through a simple request/response port. A word that is read restarts from zero, so software adds each delta into a running total. Three byte totals are 64 bits wide and appear as a low word followed by a high word. Reading the low word captures the high half so that the pair stays coherent. Counters stop at all-ones instead of wrapping. An event that arrives in the same clock as a read-clear is kept.

The read side holds no state beyond the response register: each request is answered exactly one clock later.

Top module: `stat_bank`

## Requirements
- R1: Word i (0..41) of port p sits at byte address 0x20000 + p*0x100 + 4*i. The word order is behaviour and is as follows. Receive words: 0 broadcast, 1 pause, 2 multicast, 3 FCS error, 4 alignment error, 5 runt, 6 fragment, 7..12 length bins, 13 max-size bin, 14 too-long, 15/16 good bytes low/high, 17/18 bad bytes low/high, 19 overflow, 20 filtered. Transmit words: 21 broadcast, 22 pause, 23 multicast, 24 underrun, 25..30 length bins, 31 max-size bin, 32 oversize, 33/34 bytes low/high, 35 collisions, 36 abort-collision, 37 multiple-collision, 38 single-collision, 39 excessive-deferral, 40 deferral, 41 late-collision.
- R2: When `rd_en` is high in one cycle, `rd_valid` is high in the next cycle and `rd_data` holds the word. `rd_data` is zero whenever `rd_valid` is low. A read is out of map when any of these holds: the address is misaligned, the port number is not below NPORT, the word index is above 41, or the address is outside the bank. Such a read returns zero and changes no counter.
- R3: A receive frame with error code 0 is good. It bumps the cast counter for its cast code (1 multicast, 2 broadcast, 3 pause; code 0 unicast bumps none) and one length bin, and it adds its length to good bytes.
- R4: A receive frame with a nonzero error code bumps only its error counter (1 FCS, 2 alignment, 3 runt, 4 fragment, 5 too-long, 6 overflow, 7 filtered) and adds its length to bad bytes. It touches no cast counter and no bin.
- R5: Both directions share the same length bins: up to 64 bytes, 65..127, 128..255, 256..511, 512..1023, 1024..1518, and above 1518 (the max-size bin).
- R6: A transmit frame with fault code 0, 6 or 7 is good. It bumps its cast counter, one length bin and adds its length to transmit bytes.
- R7: A transmit frame with fault code 1..5 bumps only that fault counter (1 underrun, 2 oversize, 3 abort-collision, 4 late-collision, 5 excessive-deferral), plus the collision counter under R8.
- R8: Every transmit frame adds its 4-bit collision count to the collision counter. A good transmit frame also bumps one more counter in each of these cases: single-collision when the count is exactly 1, multiple-collision when the count is 2 or more, and deferral when its defer flag is set.
- R9: A read of any word other than a 64-bit high word restarts that counter at zero.
- R10: An increment that lands in the same cycle as the read-clear of its counter is kept and becomes the counter's new value. The read returns the value from before the clear.
- R11: Reading a 64-bit low word returns the low half, captures the high half in a holding register and restarts the whole 64-bit counter. Reading the high word returns the holding register.
- R12: Every counter saturates at all-ones, both the single-word counters and the 64-bit totals.
- R13: Events on one port change only that port's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_vld | input | NPORT | Receive frame strobe, one bit per port |
| rx_len | input | NPORT*LEN_W | Receive frame length in bytes, LEN_W bits per port |
| rx_cast | input | 2*NPORT | Receive cast code per port |
| rx_code | input | 3*NPORT | Receive error code per port |
| tx_vld | input | NPORT | Transmit frame strobe per port |
| tx_len | input | NPORT*LEN_W | Transmit frame length per port |
| tx_cast | input | 2*NPORT | Transmit cast code per port |
| tx_fault | input | 3*NPORT | Transmit fault code per port |
| tx_ncoll | input | 4*NPORT | Collision count of the transmit frame per port |
| tx_defer | input | NPORT | Transmit frame was deferred |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the requested word |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | W | Read response word |

## Verification
The bench lines up a read-clear and an event on the same counter in one cycle. A design that lets the clear win would read back zero afterwards instead of one. It splits a 64-bit total across an increment between the low and high reads. If the design re-read the live high half or left the counter running, the second low read would show a stale sum. It sweeps lengths across every bin edge (64/65, 127/128, 1518/1519), because an off-by-one compare moves a frame into the neighbour bin. It drives error and fault frames that carry a broadcast code, which exposes any counting of cast or bins on bad frames. It pushes a narrow counter past all-ones to catch wrap-around. It reads misaligned and out-of-range addresses to catch aliasing onto a real counter and the clear that would follow.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int NCNT = 42;

    localparam int IX_RX_BCAST   = 0;
    localparam int IX_RX_PAUSE   = 1;
    localparam int IX_RX_MCAST   = 2;
    localparam int IX_RX_FCS     = 3;
    localparam int IX_RX_ALIGN   = 4;
    localparam int IX_RX_RUNT    = 5;
    localparam int IX_RX_FRAG    = 6;
    localparam int IX_RX_BIN0    = 7;
    localparam int IX_RX_LONG    = 14;
    localparam int IX_RX_GOOD_LO = 15;
    localparam int IX_RX_GOOD_HI = 16;
    localparam int IX_RX_BAD_LO  = 17;
    localparam int IX_RX_BAD_HI  = 18;
    localparam int IX_RX_OVF     = 19;
    localparam int IX_RX_FILT    = 20;
    localparam int IX_TX_BCAST   = 21;
    localparam int IX_TX_PAUSE   = 22;
    localparam int IX_TX_MCAST   = 23;
    localparam int IX_TX_UNDER   = 24;
    localparam int IX_TX_BIN0    = 25;
    localparam int IX_TX_OVERSZ  = 32;
    localparam int IX_TX_BYTE_LO = 33;
    localparam int IX_TX_BYTE_HI = 34;
    localparam int IX_TX_COLL    = 35;
    localparam int IX_TX_ABORT   = 36;
    localparam int IX_TX_MULTI   = 37;
    localparam int IX_TX_SINGLE  = 38;
    localparam int IX_TX_XDEFER  = 39;
    localparam int IX_TX_DEFER   = 40;
    localparam int IX_TX_LATE    = 41;

    typedef enum logic [1:0] {
        CAST_UNI   = 2'd0,
        CAST_MULTI = 2'd1,
        CAST_BROAD = 2'd2,
        CAST_PAUSE = 2'd3
    } cast_e;

    typedef enum logic [2:0] {
        RXE_NONE  = 3'd0,
        RXE_FCS   = 3'd1,
        RXE_ALIGN = 3'd2,
        RXE_RUNT  = 3'd3,
        RXE_FRAG  = 3'd4,
        RXE_LONG  = 3'd5,
        RXE_OVF   = 3'd6,
        RXE_FILT  = 3'd7
    } rx_err_e;

    typedef enum logic [2:0] {
        TXF_OK     = 3'd0,
        TXF_UNDER  = 3'd1,
        TXF_OVERSZ = 3'd2,
        TXF_ABORT  = 3'd3,
        TXF_LATE   = 3'd4,
        TXF_XDEFER = 3'd5,
        TXF_RSV6   = 3'd6,
        TXF_RSV7   = 3'd7
    } tx_fault_e;

    // Bin 0..5 are the histogram steps, 6 is the max-size bin.
    function automatic logic [2:0] size_bin(input logic [15:0] len);
        if (len <= 16'd64)        return 3'd0;
        else if (len <= 16'd127)  return 3'd1;
        else if (len <= 16'd255)  return 3'd2;
        else if (len <= 16'd511)  return 3'd3;
        else if (len <= 16'd1023) return 3'd4;
        else if (len <= 16'd1518) return 3'd5;
        else                      return 3'd6;
    endfunction

    function automatic bit pair_lo(input int i);
        return (i == IX_RX_GOOD_LO) || (i == IX_RX_BAD_LO) || (i == IX_TX_BYTE_LO);
    endfunction

    function automatic bit pair_hi(input int i);
        return (i == IX_RX_GOOD_HI) || (i == IX_RX_BAD_HI) || (i == IX_TX_BYTE_HI);
    endfunction

endpackage

// File: rtl/stat_rx_class.sv
module stat_rx_class
    import stat_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic                         vld,
    input  logic [LEN_W-1:0]             len,
    input  logic [1:0]                   cast,
    input  logic [2:0]                   code,
    output logic [NCNT-1:0][LEN_W-1:0]   inc
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_comb begin
        inc = '0;
        if (vld) begin
            if (rx_err_e'(code) == RXE_NONE) begin
                unique case (cast_e'(cast))
                    CAST_UNI:   ;
                    CAST_MULTI: inc[IX_RX_MCAST] = ONE;
                    CAST_BROAD: inc[IX_RX_BCAST] = ONE;
                    CAST_PAUSE: inc[IX_RX_PAUSE] = ONE;
                endcase
                inc[IX_RX_BIN0 + int'(size_bin(16'(len)))] = ONE;
                inc[IX_RX_GOOD_LO] = len;
            end else begin
                unique case (rx_err_e'(code))
                    RXE_FCS:   inc[IX_RX_FCS]   = ONE;
                    RXE_ALIGN: inc[IX_RX_ALIGN] = ONE;
                    RXE_RUNT:  inc[IX_RX_RUNT]  = ONE;
                    RXE_FRAG:  inc[IX_RX_FRAG]  = ONE;
                    RXE_LONG:  inc[IX_RX_LONG]  = ONE;
                    RXE_OVF:   inc[IX_RX_OVF]   = ONE;
                    RXE_FILT:  inc[IX_RX_FILT]  = ONE;
                    RXE_NONE:  ;
                endcase
                inc[IX_RX_BAD_LO] = len;
            end
        end
    end
endmodule

// File: rtl/stat_tx_class.sv
module stat_tx_class
    import stat_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic                         vld,
    input  logic [LEN_W-1:0]             len,
    input  logic [1:0]                   cast,
    input  logic [2:0]                   fault,
    input  logic [3:0]                   ncoll,
    input  logic                         defer,
    output logic [NCNT-1:0][LEN_W-1:0]   inc
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_comb begin
        inc = '0;
        if (vld) begin
            inc[IX_TX_COLL] = LEN_W'(ncoll);
            unique case (tx_fault_e'(fault))
                TXF_UNDER:  inc[IX_TX_UNDER]  = ONE;
                TXF_OVERSZ: inc[IX_TX_OVERSZ] = ONE;
                TXF_ABORT:  inc[IX_TX_ABORT]  = ONE;
                TXF_LATE:   inc[IX_TX_LATE]   = ONE;
                TXF_XDEFER: inc[IX_TX_XDEFER] = ONE;
                TXF_OK, TXF_RSV6, TXF_RSV7: begin
                    unique case (cast_e'(cast))
                        CAST_UNI:   ;
                        CAST_MULTI: inc[IX_TX_MCAST] = ONE;
                        CAST_BROAD: inc[IX_TX_BCAST] = ONE;
                        CAST_PAUSE: inc[IX_TX_PAUSE] = ONE;
                    endcase
                    inc[IX_TX_BIN0 + int'(size_bin(16'(len)))] = ONE;
                    inc[IX_TX_BYTE_LO] = len;
                    if (ncoll == 4'd1) inc[IX_TX_SINGLE] = ONE;
                    if (ncoll >= 4'd2) inc[IX_TX_MULTI]  = ONE;
                    if (defer)         inc[IX_TX_DEFER]  = ONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/stat_port.sv
module stat_port
    import stat_pkg::*;
#(
    parameter int W     = 32,
    parameter int LEN_W = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCNT-1:0][LEN_W-1:0]   inc,
    input  logic                         clr_en,
    input  logic [5:0]                   clr_idx,
    output logic [W-1:0]                 words [NCNT]
);
    for (genvar i = 0; i < NCNT; i++) begin : g_slot
        if (pair_lo(i)) begin : g_pair
            logic [2*W-1:0] acc_q;
            logic [W-1:0]   hold_q;
            logic [2*W:0]   sum;
            logic           hit;

            assign hit = clr_en && (clr_idx == 6'(i));
            assign sum = {1'b0, (hit ? {(2*W){1'b0}} : acc_q)}
                       + (2*W+1)'(inc[i])
                       + ((2*W+1)'(inc[i+1]) << W);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q  <= '0;
                    hold_q <= '0;
                end else begin
                    acc_q <= sum[2*W] ? {(2*W){1'b1}} : sum[2*W-1:0];
                    if (hit) hold_q <= acc_q[2*W-1:W];
                end
            end

            assign words[i]   = acc_q[W-1:0];
            assign words[i+1] = hold_q;
        end else if (!pair_hi(i)) begin : g_single
            logic [W-1:0] cnt_q;
            logic [W:0]   sum;
            logic         hit;

            assign hit = clr_en && (clr_idx == 6'(i));
            assign sum = {1'b0, (hit ? {W{1'b0}} : cnt_q)} + (W+1)'(inc[i]);

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= sum[W] ? {W{1'b1}} : sum[W-1:0];
            end

            assign words[i] = cnt_q;
        end
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int W      = 32,
    parameter int LEN_W  = 14,
    parameter int ADDR_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        rx_vld,
    input  logic [NPORT*LEN_W-1:0]  rx_len,
    input  logic [2*NPORT-1:0]      rx_cast,
    input  logic [3*NPORT-1:0]      rx_code,
    input  logic [NPORT-1:0]        tx_vld,
    input  logic [NPORT*LEN_W-1:0]  tx_len,
    input  logic [2*NPORT-1:0]      tx_cast,
    input  logic [3*NPORT-1:0]      tx_fault,
    input  logic [4*NPORT-1:0]      tx_ncoll,
    input  logic [NPORT-1:0]        tx_defer,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid,
    output logic [W-1:0]            rd_data
);
    localparam int                PIX_W     = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(32'h2_0000);

    logic [W-1:0] pw [NPORT][NCNT];
    logic [PIX_W-1:0] port_ix;
    logic [5:0]       word_ix;
    logic             hit;
    logic [W-1:0]     sel_word;

    assign port_ix = rd_addr[8 +: PIX_W];
    assign word_ix = rd_addr[7:2];
    assign hit = (rd_addr[ADDR_W-1:16] == BANK_BASE[ADDR_W-1:16])
              && (rd_addr[1:0] == 2'b00)
              && (rd_addr[15:8] < 8'(NPORT))
              && (word_ix < 6'(NCNT));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NCNT-1:0][LEN_W-1:0] rx_inc, tx_inc, sum_inc;

        stat_rx_class #(.LEN_W(LEN_W)) u_rx (
            .vld  (rx_vld[p]),
            .len  (rx_len[p*LEN_W +: LEN_W]),
            .cast (rx_cast[2*p +: 2]),
            .code (rx_code[3*p +: 3]),
            .inc  (rx_inc)
        );

        stat_tx_class #(.LEN_W(LEN_W)) u_tx (
            .vld   (tx_vld[p]),
            .len   (tx_len[p*LEN_W +: LEN_W]),
            .cast  (tx_cast[2*p +: 2]),
            .fault (tx_fault[3*p +: 3]),
            .ncoll (tx_ncoll[4*p +: 4]),
            .defer (tx_defer[p]),
            .inc   (tx_inc)
        );

        // receive and transmit classifiers own disjoint word ranges
        assign sum_inc = rx_inc | tx_inc;

        stat_port #(.W(W), .LEN_W(LEN_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (sum_inc),
            .clr_en  (rd_en && hit && (port_ix == PIX_W'(p))),
            .clr_idx (word_ix),
            .words   (pw[p])
        );
    end

    assign sel_word = hit ? pw[port_ix][word_ix] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? sel_word : '0;
        end
    end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
    import stat_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int W      = 32,
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORT-1:0]  rx_vld,
    input logic [NPORT-1:0]  tx_vld,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [W-1:0]      rd_data
);
    function automatic bit in_map(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - ADDR_W'(32'h2_0000);
        return (a >= ADDR_W'(32'h2_0000)) && (off[1:0] == 2'b00)
            && ((off >> 8) < NPORT) && (off[7:2] < NCNT);
    endfunction

    function automatic bit is_high(input logic [ADDR_W-1:0] a);
        return pair_hi(int'(a[7:2]));
    endfunction

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2
    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R2
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R2
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_map(rd_addr)) |=> (rd_data == '0)); // R2
    AST_REREAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && (rd_addr == $past(rd_addr)) && in_map(rd_addr)
         && !is_high(rd_addr) && ($past(rx_vld) == '0) && ($past(tx_vld) == '0))
        |=> (rd_data == '0)); // R9
endmodule

bind stat_bank stat_bank_chk #(.NPORT(NPORT), .W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_vld   (rx_vld),
    .tx_vld   (tx_vld),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/test_stat_bank.sv
module test_stat_bank;
    localparam int NP = 2;
    localparam int WW = 8;
    localparam int LW = 14;
    localparam int AW = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     rx_vld = '0;
    logic [NP*LW-1:0]  rx_len = '0;
    logic [2*NP-1:0]   rx_cast = '0;
    logic [3*NP-1:0]   rx_code = '0;
    logic [NP-1:0]     tx_vld = '0;
    logic [NP*LW-1:0]  tx_len = '0;
    logic [2*NP-1:0]   tx_cast = '0;
    logic [3*NP-1:0]   tx_fault = '0;
    logic [4*NP-1:0]   tx_ncoll = '0;
    logic [NP-1:0]     tx_defer = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              rd_valid;
    logic [WW-1:0]     rd_data;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    stat_bank #(.NPORT(NP), .W(WW), .LEN_W(LW), .ADDR_W(AW)) i_stat_bank (
        .clk(clk), .rst_n(rst_n),
        .rx_vld(rx_vld), .rx_len(rx_len), .rx_cast(rx_cast), .rx_code(rx_code),
        .tx_vld(tx_vld), .tx_len(tx_len), .tx_cast(tx_cast), .tx_fault(tx_fault),
        .tx_ncoll(tx_ncoll), .tx_defer(tx_defer),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] waddr(input int p, input int i);
        return AW'(32'h2_0000 + p * 32'h100 + i * 4);
    endfunction

    task automatic send_rx(input int p, input int len, input int cast, input int code);
        @(negedge clk);
        rx_vld = '0; rx_vld[p] = 1'b1;
        rx_len[p*LW +: LW] = LW'(len);
        rx_cast[2*p +: 2] = 2'(cast);
        rx_code[3*p +: 3] = 3'(code);
        @(negedge clk);
        rx_vld = '0;
    endtask

    task automatic send_tx(input int p, input int len, input int cast, input int fault,
                           input int ncoll, input bit defer);
        @(negedge clk);
        tx_vld = '0; tx_vld[p] = 1'b1;
        tx_len[p*LW +: LW] = LW'(len);
        tx_cast[2*p +: 2] = 2'(cast);
        tx_fault[3*p +: 3] = 3'(fault);
        tx_ncoll[4*p +: 4] = 4'(ncoll);
        tx_defer[p] = defer;
        @(negedge clk);
        tx_vld = '0;
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = 32'(rd_data);
        if (rd_valid !== 1'b1) begin
            vectors++; fails++;
            $display("FAIL R2: rd_valid got %b expected 1", rd_valid);
        end
    endtask

    task automatic rdchk(input string tag, input int p, input int i, input int exp);
        logic [31:0] d;
        read_at(waddr(p, i), d);
        chk(tag, d, 32'(exp));
    endtask

    task automatic t_reset;
        chk("R2 idle valid", 32'(rd_valid), 0);
        chk("R2 idle data", 32'(rd_data), 0);
        for (int i = 0; i < 42; i++) rdchk("R1 reset value port1", 1, i, 0);
        rdchk("R1 reset value port0 w0", 0, 0, 0);
        rdchk("R1 reset value port0 w41", 0, 41, 0);
    endtask

    task automatic t_rx_good;
        send_rx(0, 64, 0, 0);
        send_rx(0, 100, 1, 0);
        send_rx(0, 200, 2, 0);
        send_rx(0, 64, 3, 0);
        rdchk("R3 rx broadcast", 0, 0, 1);
        rdchk("R3 rx pause", 0, 1, 1);
        rdchk("R3 rx multicast", 0, 2, 1);
        rdchk("R5 rx bin 64", 0, 7, 2);
        rdchk("R5 rx bin 65-127", 0, 8, 1);
        rdchk("R5 rx bin 128-255", 0, 9, 1);
        rdchk("R3 rx good bytes low", 0, 15, 'hAC);
        rdchk("R3 rx good bytes high", 0, 16, 'h01);
    endtask

    task automatic t_bins;
        int lens [13] = '{40, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 2000};
        int exp  [7]  = '{1, 2, 2, 2, 2, 2, 2};
        logic [31:0] d;
        foreach (lens[k]) send_rx(0, lens[k], 0, 0);
        for (int b = 0; b < 7; b++) rdchk("R5 rx bin edge", 0, 7 + b, exp[b]);
        read_at(waddr(0, 15), d);
        read_at(waddr(0, 16), d);
    endtask

    task automatic t_rx_err;
        send_rx(0, 100, 2, 1);
        for (int c = 2; c < 8; c++) send_rx(0, 10, 2, c);
        rdchk("R4 rx fcs", 0, 3, 1);
        rdchk("R4 rx align", 0, 4, 1);
        rdchk("R4 rx runt", 0, 5, 1);
        rdchk("R4 rx fragment", 0, 6, 1);
        rdchk("R4 rx too-long", 0, 14, 1);
        rdchk("R4 rx overflow", 0, 19, 1);
        rdchk("R4 rx filtered", 0, 20, 1);
        rdchk("R4 rx cast ignored", 0, 0, 0);
        rdchk("R4 rx bin untouched", 0, 7, 0);
        rdchk("R4 rx good bytes untouched", 0, 15, 0);
        rdchk("R4 rx bad bytes low", 0, 17, 160);
        rdchk("R4 rx bad bytes high", 0, 18, 0);
    endtask

    task automatic t_tx;
        send_tx(0, 64, 2, 0, 0, 0);
        send_tx(0, 300, 1, 0, 0, 0);
        send_tx(0, 1600, 3, 0, 0, 0);
        send_tx(0, 70, 0, 6, 0, 0);
        for (int f = 1; f < 6; f++) send_tx(0, 50, 2, f, 0, 0);
        rdchk("R6 tx broadcast", 0, 21, 1);
        rdchk("R6 tx pause", 0, 22, 1);
        rdchk("R6 tx multicast", 0, 23, 1);
        rdchk("R6 tx bin 64", 0, 25, 1);
        rdchk("R6 tx bin 65-127 code6", 0, 26, 1);
        rdchk("R6 tx bin 128-255", 0, 27, 0);
        rdchk("R6 tx bin 256-511", 0, 28, 1);
        rdchk("R6 tx max bin", 0, 31, 1);
        rdchk("R6 tx bytes low", 0, 33, 'hF2);
        rdchk("R6 tx bytes high", 0, 34, 'h07);
        rdchk("R7 tx underrun", 0, 24, 1);
        rdchk("R7 tx oversize", 0, 32, 1);
        rdchk("R7 tx abort", 0, 36, 1);
        rdchk("R7 tx late", 0, 41, 1);
        rdchk("R7 tx excessive deferral", 0, 39, 1);
    endtask

    task automatic t_coll;
        send_tx(1, 64, 0, 0, 1, 1);
        send_tx(1, 64, 0, 0, 3, 0);
        send_tx(1, 64, 0, 3, 15, 1);
        send_tx(1, 64, 0, 0, 0, 0);
        rdchk("R8 collisions sum", 1, 35, 19);
        rdchk("R8 single collision", 1, 38, 1);
        rdchk("R8 multiple collision", 1, 37, 1);
        rdchk("R8 deferral good only", 1, 40, 1);
        rdchk("R7 abort with collisions", 1, 36, 1);
    endtask

    task automatic t_clear;
        send_rx(0, 64, 2, 0);
        send_rx(0, 64, 2, 0);
        rdchk("R9 first read", 0, 0, 2);
        rdchk("R9 read after clear", 0, 0, 0);
    endtask

    task automatic t_same_cycle;
        for (int k = 0; k < 3; k++) send_rx(0, 64, 2, 0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = waddr(0, 0);
        rx_vld = '0; rx_vld[0] = 1'b1;
        rx_len[0 +: LW] = LW'(64); rx_cast[1:0] = 2'd2; rx_code[2:0] = 3'd0;
        @(negedge clk);
        rd_en = 1'b0; rx_vld = '0;
        chk("R10 value before clear", 32'(rd_data), 3);
        rdchk("R10 increment kept", 0, 0, 1);
    endtask

    task automatic t_pair;
        for (int k = 0; k < 3; k++) send_rx(1, 1000, 0, 0);
        rdchk("R11 low word", 1, 15, 'hB8);
        send_rx(1, 10, 0, 0);
        rdchk("R11 captured high", 1, 16, 'h0B);
        rdchk("R11 restarted low", 1, 15, 10);
        rdchk("R11 high after restart", 1, 16, 0);
    endtask

    task automatic t_sat;
        for (int k = 0; k < 300; k++) send_tx(1, 64, 2, 0, 0, 0);
        rdchk("R12 word counter saturates", 1, 21, 255);
        for (int k = 0; k < 70; k++) send_rx(1, 1000, 0, 0);
        rdchk("R12 byte total low saturates", 1, 15, 255);
        rdchk("R12 byte total high saturates", 1, 16, 255);
    endtask

    task automatic t_miss;
        logic [31:0] d;
        send_rx(0, 64, 2, 0);
        read_at(AW'(32'h2_0001), d);
        chk("R2 misaligned read", d, 0);
        read_at(waddr(2, 0), d);
        chk("R2 absent port read", d, 0);
        read_at(waddr(0, 42), d);
        chk("R2 index past map", d, 0);
        read_at(AW'(32'h1_0000), d);
        chk("R2 outside bank", d, 0);
        rdchk("R2 miss left counter intact", 0, 0, 1);
    endtask

    task automatic t_ports;
        send_rx(1, 64, 1, 0);
        send_rx(1, 64, 1, 0);
        rdchk("R13 other port untouched", 0, 2, 0);
        rdchk("R13 own port counted", 1, 2, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_good();
        t_bins();
        t_rx_err();
        t_tx();
        t_coll();
        t_clear();
        t_same_cycle();
        t_pair();
        t_sat();
        t_miss();
        t_ports();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #400000;
        vectors++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule